// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Arbitration

This block is a 16-bit-wide dual-port memory with an arbiter in front of it. Each port has an active-low select, an active-low write strobe, an address and write data. Every clock the arbiter compares the two ports. When both are selected and both point at the same word, the port that got there first is granted. The other port sees its active-low busy output pulled low. While a port is busy, any write it attempts is discarded inside the block. Its reads still complete, but the returned word carries a stale flag because the other port may be changing that location.

A port counts as having arrived first when it was already selected at the same address on the previous clock and the other port was not. If neither port holds that advantage (both arrive together), a parameter chooses the winner, and by default the left port wins. Once a grant is made it stays in place for as long as the collision lasts, so the busy side cannot flip partway through an access. The address width parameter is 12, 13 or 14 bits, which gives 4K, 8K or 16K words.

Reads have one cycle of latency and are read-first: a read in the same cycle as a write to the same word returns the old contents. The stale flag is aligned with the read data it describes.

Top module: `dpram_arb`

## Requirements
- R1: When both ports are selected but their addresses differ, `busy_l_n` and `busy_r_n` are both 1.
- R2: When either select is 1, both busy outputs are 1, even if the addresses are equal.
- R3: On a new collision, the port that was selected at that same address on the previous cycle keeps busy at 1, and the other port's busy goes to 0 in the same cycle, with no clock edge in between.
- R4: `busy_l_n` and `busy_r_n` are never 0 together.
- R5: If both ports start a collision with equal standing, the right port gets busy 0 when `LEFT_WINS`=1, which is the default.
- R6: A write from a port whose busy is 0 leaves the memory unchanged, whatever that port's write strobe shows.
- R7: Once a port's busy is 0, it stays 0 on every following cycle in which the collision continues, even after both ports have become stable.
- R8: Both busy outputs return to 1 in the cycle that the address match or either select goes away.
- R9: A read made while busy is 0 returns the word one cycle later with the stale flag at 1. A read made while not busy returns it with the stale flag at 0. A cycle with no read sets the stale flag to 0.
- R10: A write (select 0, write strobe 0, not busy) stores the data. A read of that word on a later cycle returns it one cycle after the read.
- R11: While reset is held, both busy outputs are 1, both read data outputs are 0 and both stale flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_l_n | input | 1 | Left select, active low |
| we_l_n | input | 1 | Left write strobe, active low |
| addr_l | input | ADDR_W | Left word address |
| wdata_l | input | 16 | Left write data |
| rdata_l | output | 16 | Left read data, one cycle after the read |
| stale_l | output | 1 | Left read data may be stale |
| busy_l_n | output | 1 | Left busy, active low |
| cs_r_n | input | 1 | Right select, active low |
| we_r_n | input | 1 | Right write strobe, active low |
| addr_r | input | ADDR_W | Right word address |
| wdata_r | input | 16 | Right write data |
| rdata_r | output | 16 | Right read data, one cycle after the read |
| stale_r | output | 1 | Right read data may be stale |
| busy_r_n | output | 1 | Right busy, active low |

## Verification
The bench goes after arrival order in both directions. A design that ignored history, or that swapped the sides, would flag the port that arrived first. It keeps a collision going after both sides are stable: without the hold, the tie-break would hand the grant to the left port in the middle of an access. It checks ties straight after an idle cycle and after both ports move together, where a design with no fallback would flag neither port or both. It also attempts a write from the busy port and then reads the word back from the other side. A design that leaked that write would return the new data, and one without the stale flag would report the read under busy as clean.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;

    localparam int DATA_W = 16;
    localparam int MAX_AW = 14;
    localparam int N_PORT = 2;
    localparam int P_LEFT = 0;
    localparam int P_RIGHT = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // One port's select/address as seen on the previous clock
    typedef struct packed {
        logic              act;
        logic [MAX_AW-1:0] addr;
    } port_hist_t;

    function automatic logic [MAX_AW-1:0] widen(input logic [MAX_AW-1:0] a);
        return a;
    endfunction

    function automatic owner_e tie_owner(input bit left_wins);
        return left_wins ? OWN_LEFT : OWN_RIGHT;
    endfunction

endpackage

// File: rtl/dpram_arb_ctrl.sv
module dpram_arb_ctrl
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit LEFT_WINS = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_PORT-1:0]               cs_n,
    input  logic [N_PORT-1:0][ADDR_W-1:0]   addr,
    output logic [N_PORT-1:0]               busy_n
);

    port_hist_t          hist_q [N_PORT];
    logic [N_PORT-1:0]   stable;
    owner_e              owner_q, owner_d;
    logic                match;

    assign match = !cs_n[P_LEFT] && !cs_n[P_RIGHT] &&
                   (addr[P_LEFT] == addr[P_RIGHT]);

    // Per-port history: was this port already parked at this address?
    for (genvar p = 0; p < N_PORT; p++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[p] <= '0;
            end else begin
                hist_q[p].act  <= !cs_n[p];
                hist_q[p].addr <= widen(MAX_AW'(addr[p]));
            end
        end
        assign stable[p] = !cs_n[p] && hist_q[p].act &&
                           (hist_q[p].addr == widen(MAX_AW'(addr[p])));
    end

    always_comb begin
        owner_d = OWN_NONE;
        if (match) begin
            if (owner_q != OWN_NONE)
                owner_d = owner_q;                 // grant held for the collision
            else if (stable[P_LEFT] && !stable[P_RIGHT])
                owner_d = OWN_LEFT;
            else if (stable[P_RIGHT] && !stable[P_LEFT])
                owner_d = OWN_RIGHT;
            else
                owner_d = tie_owner(LEFT_WINS);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_NONE;
        else     owner_q <= owner_d;
    end

    assign busy_n[P_LEFT]  = (owner_d != OWN_RIGHT);
    assign busy_n[P_RIGHT] = (owner_d != OWN_LEFT);

    p_never_both_r4: assert property (@(posedge clk) disable iff (rst)
        !(!busy_n[P_LEFT] && !busy_n[P_RIGHT]));

    p_diff_addr_r1: assert property (@(posedge clk) disable iff (rst)
        (addr[P_LEFT] != addr[P_RIGHT]) |-> (busy_n == 2'b11));

    p_desel_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n != 2'b00) |-> (busy_n == 2'b11));

    p_hold_left_r7: assert property (@(posedge clk) disable iff (rst)
        !busy_n[P_LEFT] |=> (match |-> !busy_n[P_LEFT]));

    p_hold_right_r7: assert property (@(posedge clk) disable iff (rst)
        !busy_n[P_RIGHT] |=> (match |-> !busy_n[P_RIGHT]));

endmodule

// File: rtl/dpram_arb_mem.sv
module dpram_arb_mem
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_PORT-1:0]               cs_n,
    input  logic [N_PORT-1:0]               we_n,
    input  logic [N_PORT-1:0]               busy_n,
    input  logic [N_PORT-1:0][ADDR_W-1:0]   addr,
    input  logic [N_PORT-1:0][DATA_W-1:0]   wdata,
    output logic [N_PORT-1:0][DATA_W-1:0]   rdata,
    output logic [N_PORT-1:0]               stale
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [N_PORT-1:0] wr_go;
    logic [N_PORT-1:0] rd_go;

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        assign wr_go[p] = !cs_n[p] && !we_n[p] && busy_n[p];
        assign rd_go[p] = !cs_n[p] && we_n[p];

        // Read-first: sees contents before this edge's writes
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[p] <= '0;
                stale[p] <= 1'b0;
            end else begin
                stale[p] <= rd_go[p] && !busy_n[p];
                if (rd_go[p]) rdata[p] <= mem_q[addr[p]];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < N_PORT; p++) begin
            if (wr_go[p]) mem_q[addr[p]] <= wdata[p];
        end
    end

    // R6: a flagged port never commits a write
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_go[P_LEFT] && wr_go[P_RIGHT] && (addr[P_LEFT] == addr[P_RIGHT])));

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter bit LEFT_WINS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_l_n,
    input  logic              we_l_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [15:0]       wdata_l,
    output logic [15:0]       rdata_l,
    output logic              stale_l,
    output logic              busy_l_n,
    input  logic              cs_r_n,
    input  logic              we_r_n,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [15:0]       wdata_r,
    output logic [15:0]       rdata_r,
    output logic              stale_r,
    output logic              busy_r_n
);

    logic [N_PORT-1:0]                cs_n_v, we_n_v, busy_n_v, stale_v;
    logic [N_PORT-1:0][ADDR_W-1:0]    addr_v;
    logic [N_PORT-1:0][DATA_W-1:0]    wdata_v, rdata_v;

    assign cs_n_v  = {cs_r_n, cs_l_n};
    assign we_n_v  = {we_r_n, we_l_n};
    assign addr_v  = {addr_r, addr_l};
    assign wdata_v = {wdata_r, wdata_l};

    dpram_arb_ctrl #(.ADDR_W(ADDR_W), .LEFT_WINS(LEFT_WINS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n_v),
        .addr   (addr_v),
        .busy_n (busy_n_v)
    );

    dpram_arb_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n_v),
        .we_n   (we_n_v),
        .busy_n (busy_n_v),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rdata  (rdata_v),
        .stale  (stale_v)
    );

    assign busy_l_n = busy_n_v[P_LEFT];
    assign busy_r_n = busy_n_v[P_RIGHT];
    assign rdata_l  = rdata_v[P_LEFT];
    assign rdata_r  = rdata_v[P_RIGHT];
    assign stale_l  = stale_v[P_LEFT];
    assign stale_r  = stale_v[P_RIGHT];

    p_stale_l_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_l_n && we_l_n && !busy_l_n) |=> stale_l);

    p_stale_r_r9: assert property (@(posedge clk) disable iff (rst)
        (!cs_r_n && we_r_n && !busy_r_n) |=> stale_r);

endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs_l_n, we_l_n, cs_r_n, we_r_n;
    logic [AW-1:0] addr_l, addr_r;
    logic [15:0]   wdata_l, wdata_r;
    logic [15:0]   rdata_l, rdata_r;
    logic          stale_l, stale_r, busy_l_n, busy_r_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;   // 250 MHz

    dpram_arb u_dut (
        .clk(clk), .rst(rst),
        .cs_l_n(cs_l_n), .we_l_n(we_l_n), .addr_l(addr_l), .wdata_l(wdata_l),
        .rdata_l(rdata_l), .stale_l(stale_l), .busy_l_n(busy_l_n),
        .cs_r_n(cs_r_n), .we_r_n(we_r_n), .addr_r(addr_r), .wdata_r(wdata_r),
        .rdata_r(rdata_r), .stale_r(stale_r), .busy_r_n(busy_r_n)
    );

    typedef struct packed {
        logic          csl;
        logic [AW-1:0] al;
        logic          csr;
        logic [AW-1:0] ar;
        logic          bl;
        logic          br;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'd5, 1'b1, 12'd5, 1'b1, 1'b1, 4'd2},   // R2 right deselected
        '{1'b0, 12'd5, 1'b0, 12'd6, 1'b1, 1'b1, 4'd1},   // R1 different words
        '{1'b0, 12'd5, 1'b0, 12'd5, 1'b1, 1'b0, 4'd3},   // R3 left was first
        '{1'b0, 12'd5, 1'b0, 12'd5, 1'b1, 1'b0, 4'd7},   // R7 hold
        '{1'b0, 12'd5, 1'b0, 12'd7, 1'b1, 1'b1, 4'd8},   // R8 match gone
        '{1'b1, 12'd5, 1'b0, 12'd7, 1'b1, 1'b1, 4'd2},
        '{1'b0, 12'd7, 1'b0, 12'd7, 1'b0, 1'b1, 4'd3},   // R3 right was first
        '{1'b0, 12'd7, 1'b0, 12'd7, 1'b0, 1'b1, 4'd7},   // R7 hold beats tie-break
        '{1'b0, 12'd7, 1'b1, 12'd7, 1'b1, 1'b1, 4'd8},   // R8 select gone
        '{1'b0, 12'd9, 1'b0, 12'd9, 1'b1, 1'b0, 4'd5},   // R5 both moved
        '{1'b1, 12'd9, 1'b1, 12'd9, 1'b1, 1'b1, 4'd2},
        '{1'b0, 12'd3, 1'b0, 12'd3, 1'b1, 1'b0, 4'd5},   // R5 from idle
        '{1'b0, 12'd3, 1'b0, 12'd3, 1'b1, 1'b0, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic cl, input logic wl, input logic [AW-1:0] al,
                         input logic [15:0] dl, input logic cr, input logic wr,
                         input logic [AW-1:0] ar, input logic [15:0] dr);
        cs_l_n = cl; we_l_n = wl; addr_l = al; wdata_l = dl;
        cs_r_n = cr; we_r_n = wr; addr_r = ar; wdata_r = dr;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        drive(1, 1, '0, '0, 1, 1, '0, '0);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy_l_n && busy_r_n, "R11 busy", {busy_l_n, busy_r_n}, 3);
        chk(rdata_l == 0 && rdata_r == 0, "R11 rdata", rdata_l ^ rdata_r, 0);
        chk(!stale_l && !stale_r, "R11 stale", {stale_l, stale_r}, 0);
        rst = 1'b0;

        // Arbitration vector walk (reads only)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].csl, 1, VECS[i].al, '0, VECS[i].csr, 1, VECS[i].ar, '0);
            #1;
            chk({busy_l_n, busy_r_n} == {VECS[i].bl, VECS[i].br},
                $sformatf("R%0d vec%0d", VECS[i].req, i),
                {busy_l_n, busy_r_n}, {VECS[i].bl, VECS[i].br});
            chk(busy_l_n || busy_r_n, "R4 exclusive", {busy_l_n, busy_r_n}, 1);
            @(negedge clk);
        end

        drive(1, 1, '0, '0, 1, 1, '0, '0);
        @(negedge clk);

        // R10 left write then read
        drive(0, 0, 12'd20, 16'hA5A5, 1, 1, 12'd20, '0);
        @(negedge clk);
        drive(0, 1, 12'd20, '0, 1, 1, 12'd20, '0);
        @(negedge clk);
        chk(rdata_l == 16'hA5A5, "R10 readback", rdata_l, 16'hA5A5);
        chk(!stale_l, "R9 clean read", stale_l, 0);

        // R6/R3: right arrives late and tries to write
        drive(0, 1, 12'd20, '0, 0, 0, 12'd20, 16'h1234);
        #1;
        chk(!busy_r_n && busy_l_n, "R3 late right", {busy_l_n, busy_r_n}, 2);
        @(negedge clk);
        chk(!busy_r_n, "R7 held during write", busy_r_n, 0);
        // now right reads under busy
        drive(0, 1, 12'd20, '0, 0, 1, 12'd20, '0);
        @(negedge clk);
        chk(rdata_r == 16'hA5A5, "R6 busy write dropped", rdata_r, 16'hA5A5);
        chk(stale_r, "R9 stale under busy", stale_r, 1);

        // release; right reads alone
        drive(1, 1, '0, '0, 0, 1, 12'd20, '0);
        #1;
        chk(busy_l_n && busy_r_n, "R8 release", {busy_l_n, busy_r_n}, 3);
        @(negedge clk);
        chk(rdata_r == 16'hA5A5, "R6 memory unchanged", rdata_r, 16'hA5A5);
        chk(!stale_r, "R9 clean after release", stale_r, 0);

        // R9 idle cycle clears the flag; R10 on right port
        drive(1, 1, '0, '0, 0, 0, 12'd31, 16'h0F0F);
        @(negedge clk);
        chk(!stale_r, "R9 no read clears", stale_r, 0);
        drive(0, 1, 12'd31, '0, 1, 1, '0, '0);
        @(negedge clk);
        chk(rdata_l == 16'h0F0F, "R10 right write seen left", rdata_l, 16'h0F0F);

        // R6 with left flagged: left arrives late and writes
        drive(1, 1, '0, '0, 0, 1, 12'd31, '0);
        @(negedge clk);
        drive(0, 0, 12'd31, 16'hDEAD, 0, 1, 12'd31, '0);
        #1;
        chk(!busy_l_n && busy_r_n, "R3 late left", {busy_l_n, busy_r_n}, 1);
        @(negedge clk);
        drive(1, 1, '0, '0, 0, 1, 12'd31, '0);
        @(negedge clk);
        chk(rdata_r == 16'h0F0F, "R6 left write dropped", rdata_r, 16'h0F0F);

        drive(1, 1, '0, '0, 1, 1, '0, '0);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule